// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Store

This block is a synchronous model of a one-bit-wide configuration memory that hands a stored bitstream to a loading device, one bit per clock. An internal address counter walks the bit array from address zero. It moves only while the chip is selected and the combined reset/enable pin is in its enabling state. The bit at the current address appears on the serial output, and a separate enable flag stands in for a three-state driver.

After the top address has been consumed, the device stops for good. Its output goes quiet, and it pulls its chain-enable output low. That output drives the chip select of a second device. The second device then continues the stream on a shared data line with no gap and no repeated bit. The reset/enable pin polarity is a parameter, so members of one chain can answer either sense of a shared reset line.

A plain parallel write port fills the array, but only while the device is held in reset. The serial side has no back-pressure. Each counting clock edge both consumes the presented bit and advances to the next one, and `bit_vld` marks the cycles in which `bit_out` carries stream data.

Top module: `cfg_bitstore`

## Requirements
- R1: A rising clock edge with `sel_n`=0 and the reset function inactive advances the address by one, and `bit_out` then shows the bit stored at the new address.
- R2: While the reset function is active, the address returns to zero at the next edge, and `bit_vld`=0, `bit_out`=0 and `chain_n`=1.
- R3: With parameter `RST_HIGH`=1 (default), `rst_en`=1 means reset and `rst_en`=0 means output enabled. With `RST_HIGH`=0, the sense is inverted.
- R4: With `sel_n`=1, `idle`=1 and `bit_vld`=0, and the address does not change. When `sel_n` returns to 0, the output resumes at the same bit.
- R5: The terminal count is the highest address, 2^ADDR_W-1. The edge that consumes that bit drops `bit_vld` to 0 for good, and further edges change nothing until reset.
- R6: `chain_n`=0 exactly when `sel_n`=0, the reset function is inactive and the terminal bit has been consumed. After that point `chain_n` follows `sel_n`.
- R7: Applying reset after the terminal count raises `chain_n` to 1. On release, the stream starts again from address 0.
- R8: `wr_en`=1 with the reset function active stores `wr_bit` at `wr_addr` at the clock edge. `wr_en` has no effect while the reset function is inactive.
- R9: Two devices chained `chain_n` to `sel_n`, sharing clock and an OR-ed data line, deliver all 2·2^ADDR_W bits in address order with no gap. At most one of them has `bit_vld`=1 in any cycle.
- R10: `bit_out` is 0 whenever `bit_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; counting happens on its rising edge |
| sel_n | input | 1 | Chip select, active low; high means standby |
| rst_en | input | 1 | Combined reset / output-enable pin, polarity set by `RST_HIGH` |
| wr_en | input | 1 | Array write strobe, honoured only during reset |
| wr_addr | input | ADDR_W | Array write address |
| wr_bit | input | 1 | Array write data |
| bit_out | output | 1 | Serial data bit, 0 when not valid |
| bit_vld | output | 1 | Data output enable (three-state stand-in) |
| chain_n | output | 1 | Chain enable for the next device, active low |
| idle | output | 1 | Standby indication |

## Verification
The hardest situation to reach is the single edge at which the first device consumes its terminal bit and the second device, whose select is only released by that same edge, must present its bit zero without having counted. A close second is `sel_n` rising after the hand-off, which must pull the chain output back high and freeze the downstream device mid-stream. The bench builds a two-device chain, with the second device using the inverted reset polarity on the same line. It preloads several distinct bit patterns and samples the shared line in every cycle across the boundary. It then toggles select after the hand-off and checks that the downstream device resumes at the exact bit where it stopped.

// File: rtl/cfg_bitstore_pkg.sv
`timescale 1ns/1ps
package cfg_bitstore_pkg;

  // Address widths for the two common array sizes (2^20 and 2^19 bits).
  localparam int FULL_ADDR_W = 20;
  localparam int HALF_ADDR_W = 19;

  // Reading: bits still to deliver. Spent: terminal bit consumed.
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_SPENT = 1'b1
  } phase_e;

endpackage

// File: rtl/bs_pin_decode.sv
`timescale 1ns/1ps
module bs_pin_decode #(
  parameter bit RST_HIGH = 1'b1
) (
  input  logic rst_en,
  output logic rst_act
);

  generate
    if (RST_HIGH) begin : g_high
      assign rst_act = rst_en;
    end else begin : g_low
      assign rst_act = ~rst_en;
    end
  endgenerate

endmodule

// File: rtl/bs_bit_array.sv
`timescale 1ns/1ps
module bs_bit_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wbit,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rbit
);

  localparam int DEPTH = 1 << ADDR_W;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
  end

  assign rbit = mem[raddr];

endmodule

// File: rtl/bs_addr_ctr.sv
`timescale 1ns/1ps
module bs_addr_ctr
  import cfg_bitstore_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_act,
  input  logic              ce_act,
  output logic [ADDR_W-1:0] addr,
  output phase_e            phase
);

  localparam logic [ADDR_W-1:0] TC = '1;

  always_ff @(posedge clk) begin
    if (rst_act) begin
      addr  <= '0;
      phase <= PH_READ;
    end else if (ce_act && phase == PH_READ) begin
      if (addr == TC) phase <= PH_SPENT;
      else            addr  <= addr + 1'b1;
    end
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst_act)
    (ce_act && phase == PH_READ && addr != TC) |=> (addr == $past(addr) + 1'b1));

  // R5
  spent_frozen_chk: assert property (@(posedge clk) disable iff (rst_act)
    (phase == PH_SPENT) |=> (phase == PH_SPENT && $stable(addr)));

  // R4
  standby_hold_chk: assert property (@(posedge clk) disable iff (rst_act)
    !ce_act |=> ($stable(addr) && $stable(phase)));

  // R5
  tc_enter_chk: assert property (@(posedge clk) disable iff (rst_act)
    (ce_act && phase == PH_READ && addr == TC) |=> (phase == PH_SPENT));

endmodule

// File: rtl/cfg_bitstore.sv
`timescale 1ns/1ps
module cfg_bitstore
  import cfg_bitstore_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter bit RST_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              sel_n,
  input  logic              rst_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  output logic              bit_out,
  output logic              bit_vld,
  output logic              chain_n,
  output logic              idle
);

  logic              rst_act;
  logic              ce_act;
  logic              live;
  logic              rd_bit;
  logic [ADDR_W-1:0] addr;
  phase_e            phase;

  bs_pin_decode #(.RST_HIGH(RST_HIGH)) u_pin (
    .rst_en (rst_en),
    .rst_act(rst_act)
  );

  assign ce_act = ~sel_n;
  assign live   = ce_act & ~rst_act;

  bs_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk    (clk),
    .rst_act(rst_act),
    .ce_act (ce_act),
    .addr   (addr),
    .phase  (phase)
  );

  bs_bit_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk  (clk),
    .we   (wr_en & rst_act),
    .waddr(wr_addr),
    .wbit (wr_bit),
    .raddr(addr),
    .rbit (rd_bit)
  );

  assign bit_vld = live & (phase == PH_READ);
  assign bit_out = bit_vld & rd_bit;
  assign chain_n = ~(live & (phase == PH_SPENT));
  assign idle    = sel_n;

  // R2
  always_comb begin
    if (rst_act === 1'b1) begin
      reset_quiet_chk: assert (!bit_vld && chain_n && !bit_out);
    end
  end

  // R6
  vld_chain_excl_chk: assert property (@(posedge clk) disable iff (rst_act)
    !(bit_vld && !chain_n));

  // R4
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst_act)
    idle |-> (!bit_vld && chain_n));

  // R10
  out_zero_chk: assert property (@(posedge clk) disable iff (rst_act)
    !bit_vld |-> !bit_out);

endmodule

// File: tb/cfg_bitstore_bench.sv
`timescale 1ns/1ps
module cfg_bitstore_bench;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NROWS = 4;

  localparam logic [DEPTH-1:0] PAT_A [NROWS] = '{16'hA5C3, 16'h0001, 16'hFFFF, 16'h8000};
  localparam logic [DEPTH-1:0] PAT_B [NROWS] = '{16'h3C5A, 16'h8000, 16'h0000, 16'h7FFE};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          a_sel_n  = 1'b0;
  logic          rst_line = 1'b1;
  logic          wr_en    = 1'b0;
  logic [AW-1:0] wr_addr  = '0;
  logic          a_wbit   = 1'b0;
  logic          b_wbit   = 1'b0;

  logic a_out, a_vld, a_chain_n, a_idle;
  logic b_out, b_vld, b_chain_n, b_idle;
  logic bus;

  int total = 0;
  int bad   = 0;

  cfg_bitstore #(.ADDR_W(AW), .RST_HIGH(1'b1)) u_cfg_bitstore (
    .clk(clk), .sel_n(a_sel_n), .rst_en(rst_line),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(a_wbit),
    .bit_out(a_out), .bit_vld(a_vld), .chain_n(a_chain_n), .idle(a_idle)
  );

  cfg_bitstore #(.ADDR_W(AW), .RST_HIGH(1'b0)) u_next (
    .clk(clk), .sel_n(a_chain_n), .rst_en(~rst_line),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(b_wbit),
    .bit_out(b_out), .bit_vld(b_vld), .chain_n(b_chain_n), .idle(b_idle)
  );

  assign bus = a_out | b_out;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic preload(input logic [DEPTH-1:0] pa, input logic [DEPTH-1:0] pb);
    rst_line = 1'b1;
    wr_en    = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      wr_addr = AW'(i);
      a_wbit  = pa[i];
      b_wbit  = pb[i];
      step();
    end
    wr_en = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Vector table walk: preload pairs of patterns, read the chain end to end.
    for (int r = 0; r < NROWS; r++) begin
      a_sel_n = 1'b0;
      preload(PAT_A[r], PAT_B[r]);
      // R2: reset state
      check(a_vld == 1'b0, "R2 a_vld in reset", int'(a_vld), 0);
      check(b_vld == 1'b0, "R2 b_vld in reset", int'(b_vld), 0);
      check(a_chain_n == 1'b1, "R2 chain_n in reset", int'(a_chain_n), 1);
      check(bus == 1'b0, "R2 R10 bus in reset", int'(bus), 0);
      rst_line = 1'b0;
      #1;
      for (int k = 0; k < 2 * DEPTH; k++) begin
        logic e;
        e = (k < DEPTH) ? PAT_A[r][k] : PAT_B[r][k - DEPTH];
        check((int'(a_vld) + int'(b_vld)) == 1, "R9 single driver",
              int'(a_vld) + int'(b_vld), 1);
        check(bus == e, (k == DEPTH) ? "R3 R9 hand-off bit" : "R1 R9 stream bit",
              int'(bus), int'(e));
        step();
      end
      // R5, R6: both spent, both chain outputs low
      check(a_vld == 1'b0, "R5 a spent", int'(a_vld), 0);
      check(b_vld == 1'b0, "R5 b spent", int'(b_vld), 0);
      check(a_chain_n == 1'b0, "R6 a chain low", int'(a_chain_n), 0);
      check(b_chain_n == 1'b0, "R6 b chain low", int'(b_chain_n), 0);
    end

    // Directed: restart after terminal count (pattern row 3 loaded)
    rst_line = 1'b1;
    step();
    check(a_chain_n == 1'b1, "R7 chain_n raised by reset", int'(a_chain_n), 1);
    check(a_vld == 1'b0, "R2 vld low in reset", int'(a_vld), 0);
    rst_line = 1'b0;
    #1;
    check(a_vld == 1'b1 && bus == PAT_A[3][0], "R7 restart at bit 0", int'(bus), int'(PAT_A[3][0]));

    // Directed: standby freezes the counter
    step(); step(); step();
    check(bus == PAT_A[3][3], "R1 bit at address 3", int'(bus), int'(PAT_A[3][3]));
    a_sel_n = 1'b1;
    #1;
    check(a_idle == 1'b1, "R4 idle raised", int'(a_idle), 1);
    check(a_vld == 1'b0, "R4 vld low in standby", int'(a_vld), 0);
    check(bus == 1'b0, "R10 bus zero when not valid", int'(bus), 0);
    check(b_idle == 1'b1, "R4 next device idle", int'(b_idle), 1);
    step(); step();
    a_sel_n = 1'b0;
    #1;
    check(bus == PAT_A[3][3], "R4 resumed at same bit", int'(bus), int'(PAT_A[3][3]));

    // Directed: write while running is ignored
    wr_en   = 1'b1;
    wr_addr = AW'(5);
    a_wbit  = ~PAT_A[3][5];
    step();
    wr_en = 1'b0;
    check(bus == PAT_A[3][4], "R1 bit at address 4", int'(bus), int'(PAT_A[3][4]));
    step();
    check(bus == PAT_A[3][5], "R8 write outside reset ignored", int'(bus), int'(PAT_A[3][5]));

    // Directed: run to terminal count, then toggle select
    for (int i = 0; i < 11; i++) step();
    check(a_vld == 1'b0 && a_chain_n == 1'b0, "R6 hand-off after TC", int'(a_chain_n), 0);
    check(bus == PAT_B[3][0], "R9 next device bit 0", int'(bus), int'(PAT_B[3][0]));
    a_sel_n = 1'b1;
    #1;
    check(a_chain_n == 1'b1, "R6 chain follows sel high", int'(a_chain_n), 1);
    check(b_idle == 1'b1 && bus == 1'b0, "R6 next device parked", int'(bus), 0);
    step(); step();
    a_sel_n = 1'b0;
    #1;
    check(a_chain_n == 1'b0, "R6 chain follows sel low", int'(a_chain_n), 0);
    check(bus == PAT_B[3][0], "R6 next device did not move", int'(bus), int'(PAT_B[3][0]));
    step();
    check(a_vld == 1'b0, "R5 stays spent", int'(a_vld), 0);
    check(bus == PAT_B[3][1], "R9 next device bit 1", int'(bus), int'(PAT_B[3][1]));

    // Directed: active-low device is reset by the low level on its pin
    rst_line = 1'b1;
    step();
    rst_line = 1'b0;
    #1;
    for (int i = 0; i < DEPTH; i++) step();
    check(b_vld == 1'b1 && bus == PAT_B[3][0], "R3 active-low device reset to 0",
          int'(bus), int'(PAT_B[3][0]));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule